// File: doc/BRIEF.md
# Display RAM Address Counter

This block holds the 7-bit pointer a character-display controller uses to reach its display data RAM (DD) and its character generator RAM (CG). Set-address strobes load the pointer. Every data read or write access steps it by one in the direction held in an entry-mode register. While the pointer addresses the DD region, its stepping follows wrap points that change with the line layout. The three layouts are one long line of 80 cells, two lines of 40 cells with a gap between them, and one short line of 40 cells.

A second register holds the display-shift offset. It moves the start of each line's visible window and wraps that window inside its own line. The block reports the pointer, which RAM the pointer targets, and whether the cursor may be drawn. It also reports the first visible address of each line. The RAM arrays live outside the block.

Top module: `lcdac_top`

## Requirements
- R1: After reset, addr is 00h and cg_sel is 0. cursor_en is 1. The step direction is upward. win_l1 is 00h and win_l2 is 40h.
- R2: A pulse on ld_dd loads ld_val into addr and clears cg_sel. If ld_val lies outside the active layout, addr takes the start of the next line in upward order. In the 80-cell layout, 50h–7Fh gives 00h. In the two-line layout, 28h–3Fh gives 40h and 68h–7Fh gives 00h. In the short layout, 28h–7Fh gives 00h.
- R3: A pulse on ld_cg alone loads ld_val[5:0] into addr[5:0], clears addr[6] and sets cg_sel.
- R4: A pulse on ent_ld stores ent_up as the step direction, where 1 means upward. It leaves addr unchanged.
- R5: With mode 0 (80 cells, 00h–4Fh), each acc steps addr by one. Upward, 4Fh is followed by 00h. Downward, 00h is followed by 4Fh. Mode 3 behaves the same as mode 0.
- R6: With mode 1 (two lines, 00h–27h and 40h–67h), each acc steps addr by one. Upward, 27h goes to 40h and 67h goes to 00h. Downward, 40h goes to 27h and 00h goes to 67h.
- R7: With mode 2 (short line, 00h–27h), each acc steps addr by one. Upward, 27h goes to 00h. Downward, 00h goes to 27h.
- R8: While cg_sel is 1, each acc steps addr by one over the full 7-bit space, 7Fh↔00h, so addr[6] is reached by stepping.
- R9: An acc while cg_sel is 0 and addr lies outside the active layout moves addr to the line start given by R2, in either direction.
- R10: ld_dd takes priority over ld_cg, and either load takes priority over acc. With no load and no acc, addr and cg_sel hold.
- R11: A shift pulse with shift_left=1 raises the window offset by one, and with shift_left=0 lowers it by one. The offset wraps within 40 cells in modes 1 and 2 and within 80 cells in modes 0 and 3. win_l1 is the offset and win_l2 is 40h plus the offset. An offset that is too large after a layout change is reduced by 40. Shifting never moves addr.
- R12: cursor_en is 1 exactly when cg_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Line layout: 0 = 80 cells, 1 = two lines, 2 = short line, 3 = as 0 |
| ent_ld | input | 1 | Load step direction |
| ent_up | input | 1 | Direction value, 1 = upward |
| ld_dd | input | 1 | Load the pointer for DD access |
| ld_cg | input | 1 | Load the pointer for CG access |
| ld_val | input | 7 | Value for both loads |
| acc | input | 1 | One data read or write took place |
| shift | input | 1 | Shift the display window |
| shift_left | input | 1 | Shift direction, 1 = offset up |
| addr | output | 7 | Current pointer |
| cg_sel | output | 1 | Pointer targets CG RAM |
| cursor_en | output | 1 | Cursor may be drawn |
| win_l1 | output | 7 | First visible address of line 1 |
| win_l2 | output | 7 | First visible address of line 2 |

## Verification
A wrong wrap decision appears on addr in the cycle after the access that crosses a line end. The step sweeps walk every address in every layout in both directions, so each such error surfaces within one access. A wrong RAM-select state appears at once on cg_sel and cursor_en, and also one access later as a 7-bit wrap where a layout wrap was expected, or the reverse. A wrong shift offset appears on both window outputs right after the shift pulse, and a wrong normalisation appears as soon as the layout input changes.

// File: rtl/lcdac_pkg.sv
package lcdac_pkg;
   typedef enum logic [1:0] {
      LM_WIDE   = 2'd0,
      LM_DUAL   = 2'd1,
      LM_NARROW = 2'd2,
      LM_SPARE  = 2'd3
   } line_mode_e;
endpackage

// File: rtl/lcdac_legal.sv
// Range test and repair of a DD address for the active layout.
module lcdac_legal
   import lcdac_pkg::*;
#(
   parameter int AW       = 7,
   parameter int LINE_LEN = 40,
   parameter int L2_BASE  = 64
) (
   input  logic [AW-1:0] a,
   input  logic [1:0]    mode,
   output logic          in_range,
   output logic [AW-1:0] fixed
);
   localparam logic [AW-1:0] LLEN   = AW'(LINE_LEN);
   localparam logic [AW-1:0] WLEN   = AW'(2*LINE_LEN);
   localparam logic [AW-1:0] L2B    = AW'(L2_BASE);
   localparam logic [AW-1:0] L2END  = AW'(L2_BASE + LINE_LEN);

   line_mode_e lm;
   assign lm = line_mode_e'(mode);

   always_comb begin
      in_range = 1'b0;
      fixed    = '0;
      case (lm)
         LM_DUAL: begin
            in_range = (a < LLEN) || ((a >= L2B) && (a < L2END));
            fixed    = ((a >= LLEN) && (a < L2B)) ? L2B : '0;
         end
         LM_NARROW: begin
            in_range = (a < LLEN);
            fixed    = '0;
         end
         default: begin
            in_range = (a < WLEN);
            fixed    = '0;
         end
      endcase
      if (in_range) fixed = a;
   end
endmodule

// File: rtl/lcdac_step.sv
// Next pointer value after one data access.
module lcdac_step
   import lcdac_pkg::*;
#(
   parameter int AW       = 7,
   parameter int LINE_LEN = 40,
   parameter int L2_BASE  = 64
) (
   input  logic [AW-1:0] a,
   input  logic [1:0]    mode,
   input  logic          up,
   input  logic          cg,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] ONE    = AW'(1);
   localparam logic [AW-1:0] L1LAST = AW'(LINE_LEN - 1);
   localparam logic [AW-1:0] L2B    = AW'(L2_BASE);
   localparam logic [AW-1:0] L2LAST = AW'(L2_BASE + LINE_LEN - 1);
   localparam logic [AW-1:0] WLAST  = AW'(2*LINE_LEN - 1);

   logic          ok;
   logic [AW-1:0] rep;
   logic [AW-1:0] last;
   line_mode_e    lm;

   assign lm = line_mode_e'(mode);

   lcdac_legal #(.AW(AW), .LINE_LEN(LINE_LEN), .L2_BASE(L2_BASE)) u_leg (
      .a(a), .mode(mode), .in_range(ok), .fixed(rep)
   );

   assign last = (lm == LM_NARROW) ? L1LAST : WLAST;

   always_comb begin
      if (cg) begin
         nxt = up ? a + ONE : a - ONE;
      end else if (!ok) begin
         nxt = rep;
      end else if (lm == LM_DUAL) begin
         if (up)
            nxt = (a == L1LAST) ? L2B : (a == L2LAST) ? '0 : a + ONE;
         else
            nxt = (a == L2B) ? L1LAST : (a == '0) ? L2LAST : a - ONE;
      end else begin
         if (up)
            nxt = (a == last) ? '0 : a + ONE;
         else
            nxt = (a == '0) ? last : a - ONE;
      end
   end
endmodule

// File: rtl/lcdac_window.sv
// Display-shift offset and per-line visible window starts.
module lcdac_window
   import lcdac_pkg::*;
#(
   parameter int AW       = 7,
   parameter int LINE_LEN = 40,
   parameter int L2_BASE  = 64,
   parameter int NLINES   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             mode,
   input  logic                   shift,
   input  logic                   shift_left,
   output logic [NLINES-1:0][AW-1:0] win
);
   localparam logic [AW-1:0] ONE  = AW'(1);
   localparam logic [AW-1:0] LLEN = AW'(LINE_LEN);
   localparam logic [AW-1:0] WLEN = AW'(2*LINE_LEN);

   line_mode_e    lm;
   logic [AW-1:0] ofs_q, len, norm, ofs_d;

   assign lm   = line_mode_e'(mode);
   assign len  = (lm == LM_DUAL || lm == LM_NARROW) ? LLEN : WLEN;
   assign norm = (ofs_q >= len) ? ofs_q - LLEN : ofs_q;

   always_comb begin
      if (shift_left) ofs_d = (norm == len - ONE) ? '0 : norm + ONE;
      else            ofs_d = (norm == '0) ? len - ONE : norm - ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ofs_q <= '0;
      else if (shift) ofs_q <= ofs_d;
   end

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      assign win[g] = AW'(g * L2_BASE) + norm;
   end
endmodule

// File: rtl/lcdac_top.sv
module lcdac_top
   import lcdac_pkg::*;
#(
   parameter int AW       = 7,
   parameter int LINE_LEN = 40,
   parameter int L2_BASE  = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic          ent_ld,
   input  logic          ent_up,
   input  logic          ld_dd,
   input  logic          ld_cg,
   input  logic [AW-1:0] ld_val,
   input  logic          acc,
   input  logic          shift,
   input  logic          shift_left,
   output logic [AW-1:0] addr,
   output logic          cg_sel,
   output logic          cursor_en,
   output logic [AW-1:0] win_l1,
   output logic [AW-1:0] win_l2
);
   localparam int NLINES = 2;

   if (L2_BASE < LINE_LEN) begin : g_bad_gap
      $error("second line base overlaps the first line");
   end
   if (L2_BASE + LINE_LEN > 2**AW) begin : g_bad_l2
      $error("second line does not fit the pointer width");
   end
   if (2*LINE_LEN > 2**AW || LINE_LEN < 2) begin : g_bad_len
      $error("line length does not fit the pointer width");
   end

   logic [AW-1:0] addr_q, step_nxt, ld_fix;
   logic          cg_q, up_q, ld_ok;
   logic [NLINES-1:0][AW-1:0] win;

   lcdac_legal #(.AW(AW), .LINE_LEN(LINE_LEN), .L2_BASE(L2_BASE)) u_ldfix (
      .a(ld_val), .mode(mode), .in_range(ld_ok), .fixed(ld_fix)
   );

   lcdac_step #(.AW(AW), .LINE_LEN(LINE_LEN), .L2_BASE(L2_BASE)) u_step (
      .a(addr_q), .mode(mode), .up(up_q), .cg(cg_q), .nxt(step_nxt)
   );

   lcdac_window #(.AW(AW), .LINE_LEN(LINE_LEN), .L2_BASE(L2_BASE), .NLINES(NLINES)) u_win (
      .clk(clk), .rst_n(rst_n), .mode(mode), .shift(shift),
      .shift_left(shift_left), .win(win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cg_q   <= 1'b0;
         up_q   <= 1'b1;
      end else begin
         if (ent_ld) up_q <= ent_up;
         if (ld_dd) begin
            addr_q <= ld_fix;
            cg_q   <= 1'b0;
         end else if (ld_cg) begin
            addr_q <= {1'b0, ld_val[AW-2:0]};
            cg_q   <= 1'b1;
         end else if (acc) begin
            addr_q <= step_nxt;
         end
      end
   end

   assign addr      = addr_q;
   assign cg_sel    = cg_q;
   assign cursor_en = ~cg_q;
   assign win_l1    = win[0];
   assign win_l2    = win[1];
endmodule

// File: rtl/lcdac_chk.sv
module lcdac_chk #(
   parameter int AW       = 7,
   parameter int LINE_LEN = 40,
   parameter int L2_BASE  = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode,
   input logic          ld_dd,
   input logic          ld_cg,
   input logic [AW-1:0] ld_val,
   input logic          acc,
   input logic          up_q,
   input logic [AW-1:0] addr,
   input logic          cg_sel
);
   function automatic logic legal(input logic [1:0] m, input logic [AW-1:0] a);
      int v;
      v = int'(a);
      if (m == 2'd1) return (v < LINE_LEN) || (v >= L2_BASE && v < L2_BASE + LINE_LEN);
      if (m == 2'd2) return v < LINE_LEN;
      return v < 2*LINE_LEN;
   endfunction

   // R3
   cg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_cg && !ld_dd) |=> (cg_sel && !addr[AW-1] && addr[AW-2:0] == $past(ld_val[AW-2:0])));

   // R8
   cg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld_dd && !ld_cg && cg_sel) |=>
         (addr == ($past(up_q) ? AW'($past(addr) + 1'b1) : AW'($past(addr) - 1'b1))));

   // R5 R6 R7 R9
   dd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !ld_dd && !ld_cg && !cg_sel) |=> legal($past(mode), addr));

   // R2
   dd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_dd |=> (!cg_sel && legal($past(mode), addr)));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && !ld_dd && !ld_cg) |=> ($stable(addr) && $stable(cg_sel)));
endmodule

bind lcdac_top lcdac_chk #(.AW(AW), .LINE_LEN(LINE_LEN), .L2_BASE(L2_BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .ld_dd(ld_dd), .ld_cg(ld_cg),
   .ld_val(ld_val), .acc(acc), .up_q(up_q), .addr(addr), .cg_sel(cg_sel)
);

// File: tb/lcdac_top_test.sv
module lcdac_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       ent_ld = 0, ent_up = 0, ld_dd = 0, ld_cg = 0, acc = 0, shift = 0, shift_left = 0;
   logic [6:0] ld_val = '0;
   logic [6:0] addr, win_l1, win_l2;
   logic       cg_sel, cursor_en;
   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   lcdac_top uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .ent_ld(ent_ld), .ent_up(ent_up),
      .ld_dd(ld_dd), .ld_cg(ld_cg), .ld_val(ld_val), .acc(acc), .shift(shift),
      .shift_left(shift_left), .addr(addr), .cg_sel(cg_sel), .cursor_en(cursor_en),
      .win_l1(win_l1), .win_l2(win_l2)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(); @(negedge clk); endtask
   task automatic do_dd(input int v); ld_dd = 1; ld_val = 7'(v); cyc(); ld_dd = 0; endtask
   task automatic do_cg(input int v); ld_cg = 1; ld_val = 7'(v); cyc(); ld_cg = 0; endtask
   task automatic do_acc(); acc = 1; cyc(); acc = 0; endtask
   task automatic do_dir(input bit u); ent_ld = 1; ent_up = u; cyc(); ent_ld = 0; endtask
   task automatic do_shift(input bit l); shift = 1; shift_left = l; cyc(); shift = 0; endtask

   // position arithmetic over the ordered list of legal cells
   function automatic int exp_next(input int m, input int a, input bit up);
      int p, n;
      if (m == 1) begin
         p = (a < 64) ? a : a - 24;
         n = (p + (up ? 1 : 79)) % 80;
         return (n < 40) ? n : n + 24;
      end
      if (m == 2) return (a + (up ? 1 : 39)) % 40;
      return (a + (up ? 1 : 79)) % 80;
   endfunction

   function automatic int exp_fix(input int m, input int a);
      if (m == 1) return (a < 40) ? a : (a < 64) ? 64 : (a < 104) ? a : 0;
      if (m == 2) return (a < 40) ? a : 0;
      return (a < 80) ? a : 0;
   endfunction

   function automatic string step_tag(input int m);
      return (m == 1) ? "R6" : (m == 2) ? "R7" : "R5";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int a, held;
      cyc(); cyc(); rst_n = 1; cyc();
      // R1 reset state
      chk(addr == 0 && !cg_sel && cursor_en, "R1", {addr, cg_sel, cursor_en}, 1);
      chk(win_l1 == 0 && win_l2 == 7'h40, "R1", {win_l1, win_l2}, 7'h40);
      do_acc();
      chk(addr == 1, "R1 upward default", addr, 1);

      // R5 R6 R7 full step sweeps, both directions, mode 3 as mode 0
      for (int m = 0; m < 4; m++) begin
         mode = 2'(m);
         for (int d = 0; d < 2; d++) begin
            do_dir(d[0]);
            do_dd(0);
            a = 0;
            for (int k = 0; k < 85; k++) begin
               do_acc();
               a = exp_next(m, a, d[0]);
               chk(addr == 7'(a) && !cg_sel, step_tag(m), addr, a);
            end
         end
      end

      // R4 direction load alone leaves addr
      mode = 2'd1; do_dd(7'h27); held = addr;
      do_dir(1'b0);
      chk(addr == 7'(held), "R4 hold", addr, held);
      do_acc();
      chk(addr == 7'h26, "R4 down", addr, 7'h26);
      do_dir(1'b1); do_acc(); do_acc();
      chk(addr == 7'h40, "R4 up", addr, 7'h40);

      // R2 every load value in each layout
      for (int m = 0; m < 3; m++) begin
         mode = 2'(m);
         for (int v = 0; v < 128; v++) begin
            do_dd(v);
            chk(addr == 7'(exp_fix(m, v)) && !cg_sel, "R2", addr, exp_fix(m, v));
         end
      end

      // R3 R12 CG load, bit 6 dropped
      do_cg(7'h7D);
      chk(addr == 7'h3D && cg_sel, "R3", addr, 7'h3D);
      chk(!cursor_en, "R12 cursor off in CG", cursor_en, 0);
      // R8 full 7-bit stepping
      do_dir(1'b1); a = 7'h3D;
      for (int k = 0; k < 130; k++) begin
         do_acc(); a = (a + 1) % 128;
         chk(addr == 7'(a) && cg_sel, "R8 up", addr, a);
      end
      do_dir(1'b0);
      for (int k = 0; k < 10; k++) begin
         do_acc(); a = (a + 127) % 128;
         chk(addr == 7'(a), "R8 down", addr, a);
      end
      do_dd(5);
      chk(cursor_en && !cg_sel, "R12 cursor on in DD", cursor_en, 1);

      // R9 illegal after layout change
      mode = 2'd1; do_dd(7'h60);
      mode = 2'd2; do_acc();
      chk(addr == 0, "R9 down", addr, 0);
      mode = 2'd0; do_dd(7'h30);
      mode = 2'd1; do_dir(1'b1); do_acc();
      chk(addr == 7'h40, "R9 up", addr, 7'h40);

      // R10 priority and hold
      ld_dd = 1; ld_cg = 1; ld_val = 7'h45; cyc(); ld_dd = 0; ld_cg = 0;
      chk(addr == 7'h45 && !cg_sel, "R10 dd over cg", addr, 7'h45);
      ld_cg = 1; acc = 1; ld_val = 7'h12; cyc(); ld_cg = 0; acc = 0;
      chk(addr == 7'h12 && cg_sel, "R10 load over acc", addr, 7'h12);
      cyc(); cyc(); cyc();
      chk(addr == 7'h12 && cg_sel, "R10 hold", addr, 7'h12);

      // R11 window shifting
      do_dd(7'h20); mode = 2'd1;
      for (int k = 1; k <= 45; k++) begin
         do_shift(1'b1);
         chk(win_l1 == 7'(k % 40) && win_l2 == 7'(64 + k % 40), "R11 left", win_l1, k % 40);
      end
      a = 5;
      for (int k = 0; k < 45; k++) begin
         do_shift(1'b0); a = (a + 39) % 40;
         chk(win_l1 == 7'(a) && win_l2 == 7'(64 + a), "R11 right", win_l1, a);
      end
      chk(addr == 7'h20, "R11 addr untouched", addr, 7'h20);
      mode = 2'd0;
      while (win_l1 != 0) do_shift(1'b1);
      do_shift(1'b0);
      chk(win_l1 == 7'd79, "R11 wide wrap", win_l1, 79);
      mode = 2'd2; cyc();
      chk(win_l1 == 7'd39, "R11 normalise", win_l1, 39);
      do_shift(1'b1);
      chk(win_l1 == 0, "R11 narrow wrap", win_l1, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule